// File: doc/BRIEF.md
# Settable Time-of-Day Clock with Hourly Chime

This block keeps the time of day at one-second granularity and presents hours and minutes to a display as four BCD digits. A one-second tick is produced internally by dividing the system clock: a counter toggles a phase bit every `TICK_HALF` cycles, and each full period of that bit is one second. Seconds carry into minutes, and minutes carry into hours. Hours wrap at 24.

Four raw push-button inputs set the time. Each input passes through a two-stage synchroniser and a stability filter. One debounced press gives exactly one edit event. The mode button chooses whether the hour field or the minute field is being edited. Increment and decrement change the chosen field with wrap-around, and the confirm button clears the seconds count. When the running count reaches a new hour, the block pulses `chime` for one cycle. A neighbouring block uses this pulse to start the alarm tone and to send a temperature report.

While `freeze` is high, the digits shown on the display are held and the time count keeps running underneath. When `freeze` falls, the display catches up with the current time.

Top module: `hour_chime_clock`

## Requirements
- R1: After reset the outputs show 00:00 and `chime` is low. Reset also clears the seconds count and selects the hour field for editing.
- R2: The seconds count advances once every 2*`TICK_HALF` clock cycles. Second 59 carries into the next minute, minute 59 carries into the next hour, and 23:59:59 becomes 00:00:00.
- R3: `chime` goes high for exactly one cycle when a tick rolls the running count from minute 59 into minute 00, including the change from 23:59 to 00:00.
- R4: `chime` stays low when a button edit makes the minutes read 00.
- R5: Each debounced press of `btn_mode` switches the edit field between hours and minutes.
- R6: `btn_inc` and `btn_dec` add or subtract one in the selected field. Hours wrap within 0..23 and minutes within 0..59. A wrap never carries into the other field.
- R7: A debounced press of `btn_confirm` sets the seconds count to 0, so the next minute change happens 60 seconds later.
- R8: While `freeze` is high the four digit outputs do not change, and the time count keeps advancing. Within a few cycles of `freeze` falling, the outputs show the current time.
- R9: A level on a button input that lasts for fewer than `DEBOUNCE_CYCLES` cycles produces no edit.
- R10: The outputs are BCD digits. `hour_tens`:`hour_ones` hold the hour (00..23) and `min_tens`:`min_ones` hold the minute (00..59).
- R11: A button held high for any length of time gives exactly one edit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_mode | input | 1 | Raw button, active high: switches the edit field |
| btn_inc | input | 1 | Raw button, active high: adds one to the selected field |
| btn_dec | input | 1 | Raw button, active high: subtracts one from the selected field |
| btn_confirm | input | 1 | Raw button, active high: clears the seconds count |
| freeze | input | 1 | High holds the displayed digits |
| hour_tens | output | 4 | Hour tens digit, BCD |
| hour_ones | output | 4 | Hour units digit, BCD |
| min_tens | output | 4 | Minute tens digit, BCD |
| min_ones | output | 4 | Minute units digit, BCD |
| chime | output | 1 | One-cycle pulse when the running count reaches a new hour |

## Verification
The ports give no view of the seconds count or the phase of the tick, so an hour rollover is hard to place in time. The stimulus first presses confirm, which starts the minute from a known point. It then edits the time to 07:59 or 23:59 with the shortest run of presses and samples the outputs just before and just after the predicted minute change. The one-second uncertainty in the tick phase falls between those two samples. Random targets, some of which end on minute 00, are entered the same way, and after each one the bench checks that the chime count has not changed. A separate freeze window longer than two minutes shows that the count kept running while the display was held.

// File: rtl/chime_clock_pkg.sv
// Shared types and helpers for the hourly-chime clock.
// Assumes values passed to to_bcd are below 100.
package chime_clock_pkg;

    typedef enum logic {
        FLD_HOUR = 1'b0,
        FLD_MIN  = 1'b1
    } edit_field_e;

    typedef struct packed {
        logic [4:0] hh;
        logic [5:0] mm;
        logic [5:0] ss;
    } tod_t;

    // Split a binary value below 100 into {tens, ones} BCD digits.
    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] o;
        t = v / 7'd10;
        o = v - t * 7'd10;
        return {t[3:0], o[3:0]};
    endfunction

endpackage

// File: rtl/chime_tick_gen.sv
// One-second tick generator. A counter toggles a phase bit every HALF_COUNT
// cycles, and a one-cycle tick is issued on every second toggle, so the tick
// period is 2*HALF_COUNT cycles. Assumes HALF_COUNT >= 2.
module chime_tick_gen #(
    parameter int HALF_COUNT = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (HALF_COUNT > 1) ? $clog2(HALF_COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_COUNT - 1);

    logic [CW-1:0] cnt;
    logic          phase;

    // Count half periods, flip the phase bit and pulse once per full period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
            tick  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
            tick  <= phase;
        end else begin
            cnt   <= cnt + 1'b1;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/chime_btn_filter.sv
// Debounce filter for one raw button. The input is synchronised through two
// flops. The filtered level follows the input only after it has differed from
// the filtered level for STABLE_CYCLES consecutive cycles. A rising filtered
// level gives a one-cycle press pulse. Assumes STABLE_CYCLES >= 2.
module chime_btn_filter #(
    parameter int STABLE_CYCLES = 240_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [1:0]    sync;
    logic          level;
    logic [CW-1:0] cnt;

    // Bring the asynchronous button into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b00;
        else        sync <= {sync[0], raw};
    end

    // Accept a new level once it has held long enough; flag rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            cnt   <= '0;
            press <= 1'b0;
        end else if (sync[1] == level) begin
            cnt   <= '0;
            press <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            level <= sync[1];
            press <= sync[1];
        end else begin
            cnt   <= cnt + 1'b1;
            press <= 1'b0;
        end
    end

endmodule

// File: rtl/chime_tod_core.sv
// Time-of-day counter with edit handling and the hour event. Edit events take
// priority over the tick in the same cycle, so that tick is dropped. Only a
// tick-driven rollover into minute 00 raises the chime.
module chime_tod_core
    import chime_clock_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   ev_mode,
    input  logic   ev_inc,
    input  logic   ev_dec,
    input  logic   ev_confirm,
    output tod_t   tod,
    output logic   chime
);
    localparam logic [4:0] HH_MAX = 5'd23;
    localparam logic [5:0] MS_MAX = 6'd59;

    edit_field_e field;

    // Apply edits first, otherwise advance on the tick and flag a new hour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod   <= '0;
            field <= FLD_HOUR;
            chime <= 1'b0;
        end else begin
            chime <= 1'b0;
            if (ev_mode) begin
                field <= (field == FLD_HOUR) ? FLD_MIN : FLD_HOUR;
            end else if (ev_inc) begin
                if (field == FLD_HOUR) tod.hh <= (tod.hh == HH_MAX) ? 5'd0 : tod.hh + 5'd1;
                else                   tod.mm <= (tod.mm == MS_MAX) ? 6'd0 : tod.mm + 6'd1;
            end else if (ev_dec) begin
                if (field == FLD_HOUR) tod.hh <= (tod.hh == 5'd0) ? HH_MAX : tod.hh - 5'd1;
                else                   tod.mm <= (tod.mm == 6'd0) ? MS_MAX : tod.mm - 6'd1;
            end else if (ev_confirm) begin
                tod.ss <= 6'd0;
            end else if (tick) begin
                if (tod.ss != MS_MAX) begin
                    tod.ss <= tod.ss + 6'd1;
                end else begin
                    tod.ss <= 6'd0;
                    if (tod.mm != MS_MAX) begin
                        tod.mm <= tod.mm + 6'd1;
                    end else begin
                        tod.mm <= 6'd0;
                        tod.hh <= (tod.hh == HH_MAX) ? 5'd0 : tod.hh + 5'd1;
                        chime  <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/chime_display_hold.sv
// Display snapshot register. It copies the running hours and minutes as BCD
// every cycle while freeze is low and holds the last copy while freeze is high.
module chime_display_hold
    import chime_clock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze,
    input  tod_t       tod,
    output logic [7:0] hour_bcd,
    output logic [7:0] min_bcd
);
    // Refresh the shown digits unless the display is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_bcd <= 8'h00;
            min_bcd  <= 8'h00;
        end else if (!freeze) begin
            hour_bcd <= to_bcd({2'b00, tod.hh});
            min_bcd  <= to_bcd({1'b0, tod.mm});
        end
    end

endmodule

// File: rtl/hour_chime_clock.sv
// Top level: settable clock with an hourly chime. Four debounced buttons edit
// the time, a divided tick runs it, and a freezable snapshot drives the BCD
// digit outputs. Assumes all button inputs are raw and active high.
module hour_chime_clock
    import chime_clock_pkg::*;
#(
    parameter int TICK_HALF       = 6_000_000,
    parameter int DEBOUNCE_CYCLES = 240_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_mode,
    input  logic       btn_inc,
    input  logic       btn_dec,
    input  logic       btn_confirm,
    input  logic       freeze,
    output logic [3:0] hour_tens,
    output logic [3:0] hour_ones,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic       chime
);
    localparam int NUM_BTN = 4;

    logic [NUM_BTN-1:0] btn_raw;
    logic [NUM_BTN-1:0] btn_ev;
    logic               sec_tick;
    tod_t               tod_now;
    logic [7:0]         hour_bcd;
    logic [7:0]         min_bcd;

    assign btn_raw = {btn_confirm, btn_dec, btn_inc, btn_mode};

    chime_tick_gen #(.HALF_COUNT(TICK_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick)
    );

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        chime_btn_filter #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (btn_raw[b]),
            .press (btn_ev[b])
        );
    end

    chime_tod_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sec_tick),
        .ev_mode    (btn_ev[0]),
        .ev_inc     (btn_ev[1]),
        .ev_dec     (btn_ev[2]),
        .ev_confirm (btn_ev[3]),
        .tod        (tod_now),
        .chime      (chime)
    );

    chime_display_hold u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (freeze),
        .tod      (tod_now),
        .hour_bcd (hour_bcd),
        .min_bcd  (min_bcd)
    );

    assign hour_tens = hour_bcd[7:4];
    assign hour_ones = hour_bcd[3:0];
    assign min_tens  = min_bcd[7:4];
    assign min_ones  = min_bcd[3:0];

endmodule

// File: rtl/hour_chime_clock_chk.sv
// Property checker for the hourly-chime clock, bound into the top module.
module hour_chime_clock_chk
    import chime_clock_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       chime,
    input logic       tick,
    input logic       edit_any,
    input logic       freeze,
    input tod_t       tod,
    input logic [15:0] shown
);
    // R3: the hour event lasts one cycle only
    p_chime_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chime |=> !chime);

    // R3: the hour event coincides with minute 00, second 00 of the count
    p_chime_on_hour_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chime |-> (tod.mm == 6'd0 && tod.ss == 6'd0));

    // R4: the hour event only follows a tick, never an edit alone
    p_chime_from_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chime |-> $past(tick));

    // R8: a frozen display keeps its digits
    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(shown));

    // R2: the count stays inside its legal ranges
    p_tod_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tod.hh < 5'd24 && tod.mm < 6'd60 && tod.ss < 6'd60));

    // R6: minutes move only on a tick or an edit event
    p_minute_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !edit_any) |=> $stable(tod.mm));

endmodule

bind hour_chime_clock hour_chime_clock_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chime    (chime),
    .tick     (sec_tick),
    .edit_any (|btn_ev),
    .freeze   (freeze),
    .tod      (tod_now),
    .shown    ({hour_tens, hour_ones, min_tens, min_ones})
);

// File: tb/hour_chime_clock_tb.sv
module hour_chime_clock_tb;
    localparam int TICK_HALF = 50;
    localparam int DB        = 4;
    localparam int SEC       = 2 * TICK_HALF;
    localparam int HOLD      = DB + 8;
    localparam int WATCHDOG  = 200_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_mode = 1'b0, btn_inc = 1'b0, btn_dec = 1'b0, btn_confirm = 1'b0;
    logic freeze = 1'b0;
    logic [3:0] hour_tens, hour_ones, min_tens, min_ones;
    logic chime;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int chime_cnt = 0;
    int cur_h = 0, cur_m = 0;
    bit sel_min = 0;
    int t_conf = 0;
    bit done = 0;

    hour_chime_clock #(.TICK_HALF(TICK_HALF), .DEBOUNCE_CYCLES(DB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .btn_mode(btn_mode), .btn_inc(btn_inc), .btn_dec(btn_dec),
        .btn_confirm(btn_confirm), .freeze(freeze),
        .hour_tens(hour_tens), .hour_ones(hour_ones),
        .min_tens(min_tens), .min_ones(min_ones), .chime(chime)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && chime) chime_cnt <= chime_cnt + 1;
    end

    function automatic logic [15:0] exp_word(input int h, input int m);
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_time(input string req, input int h, input int m);
        check(req, {16'h0, hour_tens, hour_ones, min_tens, min_ones}, {16'h0, exp_word(h, m)});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic press(ref logic btn);
        @(negedge clk) btn = 1'b1;
        repeat (HOLD) @(negedge clk);
        btn = 1'b0;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(posedge clk);
        @(negedge clk);
    endtask

    // Confirm first, then move each field by the shortest route.
    task automatic set_time(input int h, input int m);
        int d;
        press(btn_confirm);
        t_conf = cyc;
        if (sel_min) begin press(btn_mode); sel_min = 0; end
        d = (h - cur_h + 24) % 24;
        if (d <= 12) repeat (d) press(btn_inc);
        else repeat (24 - d) press(btn_dec);
        press(btn_mode); sel_min = 1;
        d = (m - cur_m + 60) % 60;
        if (d <= 30) repeat (d) press(btn_inc);
        else repeat (60 - d) press(btn_dec);
        cur_h = h; cur_m = m;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0;
        int hh, mm;
        void'($urandom(32'd24681));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R10: reset state in BCD
        check_time("R1", 0, 0);
        check("R1", {31'd0, chime}, 32'd0);

        // R5: hour field selected after reset, mode moves to minutes
        press(btn_inc);
        check_time("R5", 1, 0);
        press(btn_mode); sel_min = 1;
        press(btn_inc);
        check_time("R5", 1, 1);

        // R6: minute wrap with no carry, R4: edit to :00 gives no chime
        press(btn_dec); press(btn_dec);
        check_time("R6", 1, 59);
        press(btn_inc);
        check_time("R6", 1, 0);
        check("R4", chime_cnt, 0);
        press(btn_mode); sel_min = 0;
        press(btn_dec); press(btn_dec);
        check_time("R6", 23, 0);
        press(btn_inc);
        check_time("R6", 0, 0);
        cur_h = 0; cur_m = 0;

        // R9: a short glitch is filtered
        @(negedge clk) btn_inc = 1'b1;
        repeat (2) @(negedge clk);
        btn_inc = 1'b0;
        repeat (30) @(negedge clk);
        check_time("R9", 0, 0);

        // R11: a long hold gives one step
        @(negedge clk) btn_inc = 1'b1;
        repeat (300) @(negedge clk);
        btn_inc = 1'b0;
        repeat (30) @(negedge clk);
        check_time("R11", 1, 0);
        cur_h = 1;

        // R2, R3, R7: rollover into a new hour at 60 s after confirm
        c0 = chime_cnt;
        set_time(7, 59);
        check_time("R6", 7, 59);
        wait_until(t_conf + 57 * SEC);
        check_time("R7", 7, 59);
        check("R3", chime_cnt - c0, 0);
        wait_until(t_conf + 62 * SEC);
        check_time("R2", 8, 0);
        check("R3", chime_cnt - c0, 1);
        cur_h = 8; cur_m = 0;

        // R2, R3: day wrap
        c0 = chime_cnt;
        set_time(23, 59);
        wait_until(t_conf + 62 * SEC);
        check_time("R2", 0, 0);
        check("R3", chime_cnt - c0, 1);
        cur_h = 0; cur_m = 0;

        // R8: freeze holds the display while the count runs on
        c0 = chime_cnt;
        set_time(10, 20);
        @(negedge clk) freeze = 1'b1;
        wait_until(t_conf + 130 * SEC);
        check_time("R8", 10, 20);
        @(negedge clk) freeze = 1'b0;
        repeat (4) @(negedge clk);
        check_time("R8", 10, 22);
        check("R4", chime_cnt - c0, 0);
        cur_h = 10; cur_m = 22;

        // R6, R4: random targets, some ending on minute 00
        for (int i = 0; i < 25; i++) begin
            hh = int'($urandom % 24);
            mm = ($urandom % 4 == 0) ? 0 : int'($urandom % 60);
            c0 = chime_cnt;
            set_time(hh, mm);
            check_time("R6", hh, mm);
            check("R4", chime_cnt - c0, 0);
        end

        finish_run();
    end

endmodule